// File: doc/BRIEF.md
# Sample-Queue Pulse-Width Modulator

This block drives one pulse-width-modulated pin. It is set up with a period, a prescale divider, a repeat count and an output mode, and it is fed a stream of 16-bit duty samples. Each sample is written into a four-entry queue through a single push strobe. The counter runs on a clock that is divided down from the core clock. A separate clock-enable input gates that divided clock, and it stands in for a choice of clock source. The pin takes its start-of-period level when the counter rolls over. It changes to the other level when the counter reaches the current duty sample.

A new sample is taken from the queue at a period boundary, once the current sample has been used for its repeat count. If the queue is empty at that point, the current sample stays in use. Single-cycle event pulses mark each rollover and each duty match. The number of queued words is reported at all times, so a feeding agent can keep the queue topped up.

Top module: `fifo_pwm_core`

## Requirements
- R1: While the block runs, the counter advances by one on every (prescale+1)-th core cycle in which `tick_en` is high. Cycles with `tick_en` low do not count toward this.
- R2: One output period lasts `period`+2 counter steps. `rollover_pulse` is high for exactly one cycle, in the cycle where the counter shows 0 again.
- R3: A `period` value of 0xFFFF gives the same period length as 0xFFFE, which is 65536 counter steps.
- R4: The queue holds up to 4 samples, and `fifo_level` reports 0 to 4. A push while the level is 4 is dropped, and that sample is never used.
- R5: `repeat_sel` value k makes each sample drive 2^k consecutive periods before the next sample is taken. This gives 1, 2, 4 or 8 periods.
- R6: In `out_mode` 0 the pin is high while the counter is below the duty sample and low otherwise. In mode 1 the pin is the inverse of mode 0. In modes 2 and 3 the pin is held low.
- R7: In the cycle after `en` rises, the counter and prescaler start at 0. In that cycle the pin shows its rollover level and the head sample has been taken from the queue. If the queue was empty, the duty is 0.
- R8: If the queue is empty at a boundary where a new sample is due, the current sample is kept.
- R9: A duty sample of 0 keeps the pin at its inactive level for the whole period. A sample of `period`+2 or more keeps it at its active level.
- R10: `compare_pulse` is high for one cycle in the cycle where the counter reaches the duty value. It does not occur for a sample of 0 or a sample of `period`+2 or more, and it never coincides with `rollover_pulse`.
- R11: When `en` goes low, the pin is low from the next cycle on. After that no events occur, and the queue contents are kept.
- R12: After reset the pin, both event outputs and `fifo_level` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; a rising edge starts a fresh period |
| tick_en | input | 1 | Clock enable for the prescaler (stands for the selected clock source) |
| prescale | input | 12 | Divider minus one for the counter clock |
| period | input | 16 | Period setting; the period is this value plus 2 steps |
| repeat_sel | input | 2 | Each sample is used 2^repeat_sel periods |
| out_mode | input | 2 | 0 = high then low, 1 = low then high, 2/3 = pin held low |
| push | input | 1 | Write `push_data` into the sample queue |
| push_data | input | 16 | Duty sample to queue |
| pwm_out | output | 1 | Modulated pin |
| rollover_pulse | output | 1 | One-cycle pulse at each period start |
| compare_pulse | output | 1 | One-cycle pulse when the counter reaches the duty value |
| fifo_level | output | 3 | Number of queued samples, 0 to 4 |

## Verification
The counter, the event pulses, the duty register and `fifo_level` are all registers. `pwm_out` is decoded from them without any further register. A rise of `en` applied after one edge therefore shows the fresh period at the falling edge one cycle later. A push shows in `fifo_level` right after the edge that takes it in. A rollover or a duty match shows in the same cycle as the pin change it causes. A scoreboard holds, for each expected period, the period length in core cycles, the cycles with the pin high and the number of compare pulses, all worked out from the settings. The monitor counts these at every falling edge and compares them each time `rollover_pulse` is seen. When the clock enable alternates, the first period after a start depends on the phase of the enable, so that period is not scored.

// File: rtl/fifo_pwm_core.sv
module fifo_pwm_core #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 12,
  parameter int DEPTH = 4,
  parameter int REP_W = 2,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick_en,
  input  logic [PSC_W-1:0] prescale,
  input  logic [CNT_W-1:0] period,
  input  logic [REP_W-1:0] repeat_sel,
  input  logic [1:0]       out_mode,
  input  logic             push,
  input  logic [CNT_W-1:0] push_data,
  output logic             pwm_out,
  output logic             rollover_pulse,
  output logic             compare_pulse,
  output logic [LVL_W-1:0] fifo_level
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int RC_W = (1 << REP_W) - 1;

  logic             run_q;
  logic [PSC_W-1:0] psc;
  logic [CNT_W-1:0] cnt, duty;
  logic [RC_W-1:0]  rep_cnt;
  logic [CNT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_ptr, wr_ptr;
  logic [LVL_W-1:0] level;

  wire active   = en & run_q;
  wire start    = en & ~run_q;
  wire [CNT_W-1:0] plim    = (period == '1) ? {{(CNT_W-1){1'b1}}, 1'b0} : period;
  wire [CNT_W-1:0] wrap_at = plim + 1'b1;
  wire step     = active & tick_en & (psc == prescale);
  wire wrap     = step & (cnt >= wrap_at);
  wire last_rep = (rep_cnt == RC_W'((1 << repeat_sel) - 1));
  wire nonempty = (level != '0);
  wire pop      = (start | (wrap & last_rep)) & nonempty;
  wire push_ok  = push & (level != LVL_W'(DEPTH));
  wire below    = run_q & (cnt < duty);

  assign pwm_out    = (out_mode == 2'd0) ? below :
                      (out_mode == 2'd1) ? (run_q & ~below) : 1'b0;
  assign fifo_level = level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q          <= 1'b0;
      psc            <= '0;
      cnt            <= '0;
      rollover_pulse <= 1'b0;
      compare_pulse  <= 1'b0;
    end else begin
      run_q          <= en;
      rollover_pulse <= wrap;
      compare_pulse  <= step & ~wrap & (CNT_W'(cnt + 1'b1) == duty);
      if (!active) begin
        psc <= '0;
        cnt <= '0;
      end else if (tick_en) begin
        psc <= (psc == prescale) ? '0 : psc + 1'b1;
        if (step) cnt <= wrap ? '0 : cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty    <= '0;
      rep_cnt <= '0;
    end else if (start) begin
      duty    <= nonempty ? mem[rd_ptr] : '0;
      rep_cnt <= '0;
    end else if (wrap) begin
      if (last_rep && nonempty) duty <= mem[rd_ptr];
      rep_cnt <= last_rep ? '0 : rep_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)     rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/fifo_pwm_core_chk.sv
module fifo_pwm_core_chk #(
  parameter int CNT_W = 16,
  parameter int DEPTH = 4,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             push,
  input logic [1:0]       out_mode,
  input logic             pwm_out,
  input logic             rollover_pulse,
  input logic             compare_pulse,
  input logic [LVL_W-1:0] fifo_level,
  input logic [CNT_W-1:0] cnt
);
  assert_roll_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rollover_pulse |=> !rollover_pulse);

  assert_roll_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rollover_pulse |-> (cnt == '0));

  assert_cmp_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    compare_pulse |=> !compare_pulse);

  assert_events_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rollover_pulse && compare_pulse));

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  assert_full_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && fifo_level == LVL_W'(DEPTH)) |=> (fifo_level >= LVL_W'(DEPTH - 1)));

  assert_off_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_mode[1] |-> !pwm_out);

  assert_disabled_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_out);
endmodule

bind fifo_pwm_core fifo_pwm_core_chk #(
  .CNT_W(CNT_W), .DEPTH(DEPTH), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .push(push), .out_mode(out_mode),
  .pwm_out(pwm_out), .rollover_pulse(rollover_pulse),
  .compare_pulse(compare_pulse), .fifo_level(fifo_level), .cnt(cnt)
);

// File: tb/fifo_pwm_core_tb_top.sv
`timescale 1ns/1ps
module fifo_pwm_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        tick_en = 1'b1;
  logic [11:0] prescale = '0;
  logic [15:0] period = '0;
  logic [1:0]  repeat_sel = '0;
  logic [1:0]  out_mode = '0;
  logic        push = 1'b0;
  logic [15:0] push_data = '0;
  logic        pwm_out, rollover_pulse, compare_pulse;
  logic [2:0]  fifo_level;

  always #2 clk = ~clk;

  fifo_pwm_core dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .tick_en(tick_en), .prescale(prescale),
    .period(period), .repeat_sel(repeat_sel), .out_mode(out_mode), .push(push),
    .push_data(push_data), .pwm_out(pwm_out), .rollover_pulse(rollover_pulse),
    .compare_pulse(compare_pulse), .fifo_level(fifo_level)
  );

  typedef struct {
    int    hi;
    int    len;
    int    cmp;
    bit    scored;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad = 0;
  bit   alt_tick = 1'b0;
  bit   finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial forever begin
    @(posedge clk);
    #1 tick_en = alt_tick ? ~tick_en : 1'b1;
  end

  // monitor: accumulate per-period measurements, score at each rollover
  bit en_d = 1'b0, en_dd = 1'b0;
  int acc_hi = 0, acc_len = 0, acc_cmp = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rollover_pulse) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11", "unexpected rollover", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.scored) begin
            check(acc_len == e.len, "R2", {e.tag, " period cycles"}, acc_len, e.len);
            check(acc_hi == e.hi, "R6", {e.tag, " high cycles"}, acc_hi, e.hi);
            check(acc_cmp == e.cmp, "R10", {e.tag, " compare pulses"}, acc_cmp, e.cmp);
          end
        end
        acc_hi = 0; acc_len = 0; acc_cmp = 0;
      end
      if (en_d && !en_dd) begin
        acc_hi = 0; acc_len = 0; acc_cmp = 0;
      end
      acc_len++;
      if (pwm_out) acc_hi++;
      if (compare_pulse) acc_cmp++;
      en_dd = en_d;
      en_d  = en;
    end
  end

  task automatic run_case(input string tag, input int ps, input int per,
                          input int mode, input int rep, input logic [15:0] s [5],
                          input int n, input int nper, input bit alt);
    int m, peff, stepc, len;
    m = (n > 4) ? 4 : n;
    prescale = 12'(ps); period = 16'(per); out_mode = 2'(mode); repeat_sel = 2'(rep);
    for (int k = 0; k < n; k++) begin
      push = 1'b1; push_data = s[k];
      @(posedge clk); #1 push = 1'b0;
      @(negedge clk);
      check(int'(fifo_level) == ((k + 1 > 4) ? 4 : k + 1), "R4",
            {tag, " level after push"}, int'(fifo_level), (k + 1 > 4) ? 4 : k + 1);
    end
    peff  = (per == 65535) ? 65534 : per;
    stepc = (ps + 1) * (alt ? 2 : 1);
    len   = (peff + 2) * stepc;
    for (int k = 0; k < nper; k++) begin
      exp_t e;
      int idx, d, a;
      idx = k / (1 << rep);
      d = (m == 0) ? 0 : int'(s[(idx < m - 1) ? idx : m - 1]);
      a = ((d < peff + 2) ? d : peff + 2) * stepc;
      e.len = len;
      e.hi  = (mode == 0) ? a : (mode == 1) ? len - a : 0;
      e.cmp = (d > 0 && d < peff + 2) ? 1 : 0;
      e.scored = !(alt && k == 0);
      e.tag = tag;
      exp_q.push_back(e);
    end
    @(posedge clk); #1 en = 1'b1; alt_tick = alt;
    @(negedge clk); @(negedge clk);
    begin
      int d0, lvl_exp;
      bit act, pin_exp;
      d0 = (m > 0) ? int'(s[0]) : 0;
      act = (d0 > 0);
      pin_exp = (mode == 0) ? act : (mode == 1) ? !act : 1'b0;
      lvl_exp = (m > 0) ? m - 1 : 0;
      check(pwm_out == pin_exp, "R7", {tag, " pin at start"}, int'(pwm_out), int'(pin_exp));
      check(int'(fifo_level) == lvl_exp, "R7", {tag, " level after start pop"},
            int'(fifo_level), lvl_exp);
    end
    wait (exp_q.size() == 0);
    @(posedge clk); #1 en = 1'b0; alt_tick = 1'b0;
    @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(pwm_out == 1'b0, "R11", {tag, " pin after disable"}, int'(pwm_out), 0);
    end
    check(fifo_level == 3'd0, "R4", {tag, " queue drained"}, int'(fifo_level), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "R2", "watchdog expired", 0, 1);
    wrap_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(pwm_out == 1'b0, "R12", "pin after reset", int'(pwm_out), 0);
    check(rollover_pulse == 1'b0 && compare_pulse == 1'b0, "R12", "events after reset",
          int'({rollover_pulse, compare_pulse}), 0);
    check(fifo_level == 3'd0, "R12", "level after reset", int'(fifo_level), 0);

    run_case("R8 mode0 hold last",   0, 6,     0, 0, '{16'd3, 16'd5, 16'd0, 16'd0, 16'd0}, 2, 3,  1'b0);
    run_case("R1 prescale 3",        3, 4,     0, 0, '{16'd2, 16'd0, 16'd0, 16'd0, 16'd0}, 1, 2,  1'b0);
    run_case("R6 mode1",             1, 5,     1, 0, '{16'd4, 16'd1, 16'd0, 16'd0, 16'd0}, 2, 3,  1'b0);
    run_case("R6 mode2 off",         0, 3,     2, 0, '{16'd2, 16'd0, 16'd0, 16'd0, 16'd0}, 1, 2,  1'b0);
    run_case("R5 repeat x2",         0, 6,     0, 1, '{16'd1, 16'd3, 16'd5, 16'd0, 16'd0}, 3, 6,  1'b0);
    run_case("R5 repeat x4",         0, 6,     0, 2, '{16'd2, 16'd6, 16'd0, 16'd0, 16'd0}, 2, 6,  1'b0);
    run_case("R5 repeat x8",         0, 2,     0, 3, '{16'd1, 16'd4, 16'd0, 16'd0, 16'd0}, 2, 10, 1'b0);
    run_case("R9 zero and full",     0, 4,     0, 0, '{16'd0, 16'd6, 16'd9, 16'd0, 16'd0}, 3, 3,  1'b0);
    run_case("R4 full drop",         0, 6,     0, 0, '{16'd1, 16'd2, 16'd3, 16'd4, 16'd5}, 5, 5,  1'b0);
    run_case("R1 tick gated",        1, 3,     0, 0, '{16'd2, 16'd0, 16'd0, 16'd0, 16'd0}, 1, 3,  1'b1);
    run_case("R7 empty start",       0, 3,     0, 0, '{16'd0, 16'd0, 16'd0, 16'd0, 16'd0}, 0, 2,  1'b0);
    run_case("R3 max period",        0, 65535, 0, 0, '{16'd1, 16'd0, 16'd0, 16'd0, 16'd0}, 1, 1,  1'b0);
    wrap_up();
  end
endmodule